// File: doc/BRIEF.md
# Reset and Watchdog Output Controller

This block owns one active-low open-drain pin that serves one of two functions. As a master reset it gives a timed low pulse when software sets a trigger bit. As an over-temperature watchdog it shows the result of the temperature limit check. A second active-low open-drain output follows a single configuration bit, and can be used to hold a power switch on or to run a fan. Each output is given as a drive-enable: a 1 pulls the pad low and a 0 leaves it floating.

The register bits come in as three words: configuration, function/control and watchdog configuration. A control bit picks the pin's function. The reset pulse is timed by a slow tick of about one millisecond and always lasts at least the configured number of tick periods. When the pulse ends, the block asks the register file to clear the trigger bit. It does not react to the trigger again until it sees that bit low. The watchdog has two modes. In comparator mode it holds the pin with hysteresis. In one-shot mode it latches a limit crossing until software reads the temperature status.

Top module: `rwo_ctrl`

## Requirements
- R1: While rst_ni is low, pin_drive_o, gpo_drive_o and trig_clr_o are all 0.
- R2: With the reset function enabled (function word bit 7 = 1) and the block idle, a 1 on configuration bit 4 sets pin_drive_o to 1 one clock later.
- R3: The reset pulse ends on the clock edge that samples the (MIN_PULSE_TICKS+1)-th tick_i pulse after it started. It therefore lasts at least MIN_PULSE_TICKS full tick periods and at most MIN_PULSE_TICKS+1.
- R4: From the end of the pulse, trig_clr_o stays 1 until configuration bit 4 is sampled low. No new pulse starts while trig_clr_o is 1.
- R5: When function word bit 7 is 0, configuration bit 4 has no effect: no pulse starts and trig_clr_o stays 0.
- R6: A trigger that drops and rises again during a pulse does not restart or lengthen the pulse.
- R7: The watchdog drives the pin only when function word bit 6 = 1 and bit 7 = 0. With both bits at 1, a pending watchdog event leaves the pin released.
- R8: Comparator mode (watchdog configuration bit 2 = 0): one clock after temp_over_i is 1 the pin is driven. It stays driven until temp_below_hyst_i is sampled with temp_over_i low, and a status read does not release it.
- R9: One-shot mode (watchdog configuration bit 2 = 1): a 0-to-1 change of temp_over_i drives the pin one clock later. A status_rd_i pulse releases it one clock later. It is not driven again until temp_over_i falls and rises again, and the hysteresis input does not release it.
- R10: gpo_drive_o equals the inverse of configuration bit 6, one clock late.
- R11: When function word bits 7 and 6 are both 0, pin_drive_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_word_i | input | CFG_W | Configuration word: bit 4 reset trigger, bit 6 GPO level |
| fn_word_i | input | FN_W | Function/control word: bit 7 reset enable, bit 6 watchdog enable |
| wd_cfg_i | input | WDC_W | Watchdog configuration: bit 2 one-shot mode |
| tick_i | input | 1 | One-cycle timebase pulse, about 1 ms apart |
| temp_over_i | input | 1 | Temperature above limit |
| temp_below_hyst_i | input | 1 | Temperature below hysteresis level |
| status_rd_i | input | 1 | Temperature status read strobe |
| pin_drive_o | output | 1 | Pull shared pin low |
| gpo_drive_o | output | 1 | Pull general-purpose output low |
| trig_clr_o | output | 1 | Request to clear the reset trigger bit |

## Verification
The assertions assume that tick_i is a single-cycle pulse, that the register words change only between clock edges, and that temp_over_i and temp_below_hyst_i are never high together. The stimulus drives every input on the falling edge and generates ticks every 20 cycles from a free-running loop. It keeps the two temperature levels mutually exclusive. Between scenarios it returns the watchdog flag to its cleared state, so the result of one mode never carries into the next.

// File: rtl/rwo_pkg.sv
package rwo_pkg;
  typedef enum logic [1:0] {
    PT_IDLE    = 2'd0,
    PT_PULSE   = 2'd1,
    PT_RELEASE = 2'd2
  } pt_state_e;

  typedef struct packed {
    logic rst_en;
    logic wd_en;
    logic trig;
    logic gpo_level;
    logic one_shot;
  } ctl_bits_t;
endpackage

// File: rtl/rwo_field_decode.sv
module rwo_field_decode
  import rwo_pkg::*;
#(
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned FN_W        = 8,
  parameter int unsigned WDC_W       = 8,
  parameter int unsigned TRIG_BIT    = 4,
  parameter int unsigned GPO_BIT     = 6,
  parameter int unsigned RST_EN_BIT  = 7,
  parameter int unsigned WD_EN_BIT   = 6,
  parameter int unsigned WD_MODE_BIT = 2
) (
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic [FN_W-1:0]  fn_word_i,
  input  logic [WDC_W-1:0] wd_cfg_i,
  output ctl_bits_t        ctl_o
);
  logic unused_bits;
  assign unused_bits = ^{cfg_word_i, fn_word_i, wd_cfg_i};

  always_comb begin
    ctl_o.rst_en    = fn_word_i[RST_EN_BIT];
    ctl_o.wd_en     = fn_word_i[WD_EN_BIT];
    ctl_o.trig      = cfg_word_i[TRIG_BIT];
    ctl_o.gpo_level = cfg_word_i[GPO_BIT];
    ctl_o.one_shot  = wd_cfg_i[WD_MODE_BIT];
  end
endmodule

// File: rtl/rwo_pulse_timer.sv
module rwo_pulse_timer
  import rwo_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trig_i,
  input  logic tick_i,
  output logic active_o,
  output logic clr_req_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);

  pt_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PT_IDLE: begin
        if (en_i && trig_i) begin
          state_d = PT_PULSE;
          cnt_d   = '0;
        end
      end
      PT_PULSE: begin
        // trigger level is not looked at here: retrigger has no effect
        if (tick_i) begin
          if (cnt_q == LAST) state_d = PT_RELEASE;
          else               cnt_d   = cnt_q + 1'b1;
        end
      end
      PT_RELEASE: begin
        if (!trig_i) state_d = PT_IDLE;
      end
      default: state_d = PT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PT_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o  = (state_q == PT_PULSE);
  assign clr_req_o = (state_q == PT_RELEASE);
endmodule

// File: rtl/rwo_temp_watch.sv
module rwo_temp_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic one_shot_i,
  input  logic over_i,
  input  logic below_hyst_i,
  input  logic rd_i,
  output logic flag_o
);
  logic over_q, flag_q, flag_d, rise;

  assign rise = over_i & ~over_q;

  always_comb begin
    flag_d = flag_q;
    if (one_shot_i) begin
      if (rise)      flag_d = 1'b1;
      else if (rd_i) flag_d = 1'b0;
    end else begin
      if (over_i)            flag_d = 1'b1;
      else if (below_hyst_i) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      over_q <= over_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rwo_pin_drive.sv
module rwo_pin_drive
  import rwo_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ctl_bits_t ctl_i,
  input  logic      pulse_active_i,
  input  logic      wd_flag_i,
  output logic      pin_drive_o,
  output logic      gpo_drive_o
);
  logic wd_sel, gpo_q;

  // reset function takes the pin whenever its enable is set
  assign wd_sel      = ctl_i.wd_en & ~ctl_i.rst_en;
  assign pin_drive_o = (ctl_i.rst_en & pulse_active_i) | (wd_sel & wd_flag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gpo_q <= 1'b0;
    else         gpo_q <= ~ctl_i.gpo_level;
  end

  assign gpo_drive_o = gpo_q;
endmodule

// File: rtl/rwo_ctrl.sv
module rwo_ctrl
  import rwo_pkg::*;
#(
  parameter int unsigned CFG_W           = 8,
  parameter int unsigned FN_W            = 8,
  parameter int unsigned WDC_W           = 8,
  parameter int unsigned TRIG_BIT        = 4,
  parameter int unsigned GPO_BIT         = 6,
  parameter int unsigned RST_EN_BIT      = 7,
  parameter int unsigned WD_EN_BIT       = 6,
  parameter int unsigned WD_MODE_BIT     = 2,
  parameter int unsigned MIN_PULSE_TICKS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic [FN_W-1:0]  fn_word_i,
  input  logic [WDC_W-1:0] wd_cfg_i,
  input  logic             tick_i,
  input  logic             temp_over_i,
  input  logic             temp_below_hyst_i,
  input  logic             status_rd_i,
  output logic             pin_drive_o,
  output logic             gpo_drive_o,
  output logic             trig_clr_o
);
  // one extra tick absorbs the unknown tick phase at pulse start
  localparam int unsigned PULSE_TICKS = MIN_PULSE_TICKS + 1;

  ctl_bits_t ctl;
  logic      pulse_active, wd_flag;

  rwo_field_decode #(
    .CFG_W(CFG_W), .FN_W(FN_W), .WDC_W(WDC_W),
    .TRIG_BIT(TRIG_BIT), .GPO_BIT(GPO_BIT),
    .RST_EN_BIT(RST_EN_BIT), .WD_EN_BIT(WD_EN_BIT), .WD_MODE_BIT(WD_MODE_BIT)
  ) u_decode (
    .cfg_word_i (cfg_word_i),
    .fn_word_i  (fn_word_i),
    .wd_cfg_i   (wd_cfg_i),
    .ctl_o      (ctl)
  );

  rwo_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ctl.rst_en),
    .trig_i    (ctl.trig),
    .tick_i    (tick_i),
    .active_o  (pulse_active),
    .clr_req_o (trig_clr_o)
  );

  rwo_temp_watch u_watch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .one_shot_i   (ctl.one_shot),
    .over_i       (temp_over_i),
    .below_hyst_i (temp_below_hyst_i),
    .rd_i         (status_rd_i),
    .flag_o       (wd_flag)
  );

  rwo_pin_drive u_pin (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctl_i          (ctl),
    .pulse_active_i (pulse_active),
    .wd_flag_i      (wd_flag),
    .pin_drive_o    (pin_drive_o),
    .gpo_drive_o    (gpo_drive_o)
  );
endmodule

// File: rtl/rwo_ctrl_chk.sv
module rwo_ctrl_chk #(
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned FN_W        = 8,
  parameter int unsigned WDC_W       = 8,
  parameter int unsigned GPO_BIT     = 6,
  parameter int unsigned RST_EN_BIT  = 7,
  parameter int unsigned WD_EN_BIT   = 6,
  parameter int unsigned WD_MODE_BIT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CFG_W-1:0] cfg_word_i,
  input logic [FN_W-1:0]  fn_word_i,
  input logic [WDC_W-1:0] wd_cfg_i,
  input logic             tick_i,
  input logic             temp_over_i,
  input logic             pin_drive_o,
  input logic             gpo_drive_o,
  input logic             trig_clr_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic rst_en, wd_en, comp_sel;
  assign rst_en   = fn_word_i[RST_EN_BIT];
  assign wd_en    = fn_word_i[WD_EN_BIT];
  assign comp_sel = wd_en & ~rst_en & ~wd_cfg_i[WD_MODE_BIT];

  // R10
  gpo_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> gpo_drive_o == !$past(cfg_word_i[GPO_BIT]));

  // R11
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_en && !wd_en) |-> !pin_drive_o);

  // R3
  pulse_end_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && rst_en && $past(rst_en) && $fell(pin_drive_o)) |-> $past(tick_i));

  // R4
  clr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_clr_o && rst_en) |-> !pin_drive_o);

  // R8
  comp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_sel && temp_over_i) |=> (pin_drive_o || !comp_sel));
endmodule

bind rwo_ctrl rwo_ctrl_chk #(
  .CFG_W(CFG_W), .FN_W(FN_W), .WDC_W(WDC_W), .GPO_BIT(GPO_BIT),
  .RST_EN_BIT(RST_EN_BIT), .WD_EN_BIT(WD_EN_BIT), .WD_MODE_BIT(WD_MODE_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_word_i  (cfg_word_i),
  .fn_word_i   (fn_word_i),
  .wd_cfg_i    (wd_cfg_i),
  .tick_i      (tick_i),
  .temp_over_i (temp_over_i),
  .pin_drive_o (pin_drive_o),
  .gpo_drive_o (gpo_drive_o),
  .trig_clr_o  (trig_clr_o)
);

// File: tb/rwo_ctrl_tb_top.sv
module rwo_ctrl_tb_top;
  localparam int TICK_P = 20;
  localparam int MIN_T  = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg = 8'h00, fn = 8'h00, wdc = 8'h00;
  logic       tick = 1'b0, over = 1'b0, hyst = 1'b1, rd = 1'b0;
  logic       pin, gpo, clr;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rwo_ctrl #(.MIN_PULSE_TICKS(MIN_T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_word_i(cfg), .fn_word_i(fn),
    .wd_cfg_i(wdc), .tick_i(tick), .temp_over_i(over),
    .temp_below_hyst_i(hyst), .status_rd_i(rd),
    .pin_drive_o(pin), .gpo_drive_o(gpo), .trig_clr_o(clr)
  );

  initial begin
    forever begin
      repeat (TICK_P - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 pin in reset", int'(pin), 0);
    check("R1 gpo in reset", int'(gpo), 0);
    check("R1 clr in reset", int'(clr), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_gpo();
    cfg[6] = 1'b0;
    @(negedge clk);
    check("R10 gpo low level", int'(gpo), 1);
    cfg[6] = 1'b1;
    @(negedge clk);
    check("R10 gpo high level", int'(gpo), 0);
    cfg[6] = 1'b0;
    @(negedge clk);
    check("R10 gpo back", int'(gpo), 1);
  endtask

  task automatic measure(output int len);
    len = 1;
    @(negedge clk);
    while (pin) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_pulse(input bit retrig);
    int len;
    fn = 8'h80;
    @(negedge clk);
    cfg[4] = 1'b1;
    @(negedge clk);
    check("R2 pulse start", int'(pin), 1);
    if (retrig) begin
      repeat (30) @(negedge clk);
      cfg[4] = 1'b0;
      repeat (5) @(negedge clk);
      cfg[4] = 1'b1;
      repeat (60) @(negedge clk);
      len = 96;
      while (pin) begin
        len++;
        @(negedge clk);
      end
      check_range("R6 retrigger length", len, MIN_T * TICK_P, (MIN_T + 1) * TICK_P + 1);
    end else begin
      measure(len);
      check_range("R3 pulse length", len, MIN_T * TICK_P, (MIN_T + 1) * TICK_P + 1);
    end
    check("R4 clear request", int'(clr), 1);
    repeat (4) @(negedge clk);
    check("R4 no restart while clr", int'(pin), 0);
    check("R4 clr held", int'(clr), 1);
    cfg[4] = 1'b0;
    @(negedge clk);
    check("R4 clr dropped", int'(clr), 0);
  endtask

  task automatic t_disabled();
    fn = 8'h00;
    cfg[4] = 1'b1;
    repeat (40) @(negedge clk);
    check("R5 no pulse", int'(pin), 0);
    check("R5 no clr", int'(clr), 0);
    cfg[4] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_comparator();
    fn = 8'h40; wdc = 8'h00;
    hyst = 1'b0; over = 1'b1;
    @(negedge clk);
    check("R8 assert over", int'(pin), 1);
    over = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hold in band", int'(pin), 1);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
    check("R8 read no release", int'(pin), 1);
    hyst = 1'b1;
    @(negedge clk);
    check("R8 release below hyst", int'(pin), 0);
  endtask

  task automatic t_oneshot();
    fn = 8'h40; wdc = 8'h04;
    over = 1'b0; hyst = 1'b0;
    repeat (2) @(negedge clk);
    over = 1'b1;
    @(negedge clk);
    check("R9 assert on rise", int'(pin), 1);
    over = 1'b0; hyst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 hyst no release", int'(pin), 1);
    hyst = 1'b0; over = 1'b1;
    repeat (2) @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R9 read release", int'(pin), 0);
    repeat (4) @(negedge clk);
    check("R9 no reassert while over", int'(pin), 0);
    over = 1'b0;
    @(negedge clk);
    over = 1'b1;
    @(negedge clk);
    check("R9 reassert on new rise", int'(pin), 1);
    over = 1'b0; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0; hyst = 1'b1; wdc = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_select();
    wdc = 8'h00; hyst = 1'b0; over = 1'b1;
    fn = 8'hC0;
    repeat (2) @(negedge clk);
    check("R7 both enables no watchdog", int'(pin), 0);
    fn = 8'h00;
    @(negedge clk);
    check("R11 none enabled", int'(pin), 0);
    fn = 8'h40;
    @(negedge clk);
    check("R7 watchdog selected", int'(pin), 1);
    over = 1'b0; hyst = 1'b1;
    @(negedge clk);
    check("R7 watchdog cleared", int'(pin), 0);
  endtask

  initial begin
    t_reset();
    t_gpo();
    t_pulse(1'b0);
    t_pulse(1'b1);
    t_disabled();
    t_comparator();
    t_oneshot();
    t_select();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule